// File: doc/BRIEF.md
# Sixteen-Line Masked Vectored Interrupt Extension

This block gathers sixteen interrupt request lines, gates them with a mask that software loads, and picks one pending line that the mask allows. It then gives the processor a pending flag and a vector address. Line n maps to octal address 064 + (n-1), so the lines occupy octal 064 through 103. Fifteen of the lines come from external devices, and each device holds its request level until it clears it. The sixteenth line is a task-ready flag inside the block. Software raises this flag with a control pulse, and the flag drops when the processor acknowledges its vector.

Software reaches the block over a pulse-style I/O bus. The bus carries a device address, a function code, and one strobe each for control pulses, output words and input words. Device octal 20 holds two mask registers: the extension mask and a separate standard-bank mask. Device octal 41 posts the task flag and returns a fixed node number. A global enable input stops any vector from being presented. When several allowed lines are pending, the lowest-numbered one wins.

Top module: `irqx_unit`

## Requirements
- R1: Each selected line n (1 to 16) gives a vector of octal 064 + (n-1), so line 1 gives 064, line 15 gives 102 and line 16 gives 103. `irqPending` is high whenever a vector is presented.
- R2: A mask bit of 1 blocks its line and a mask bit of 0 lets it through. Bit k of the extension mask governs line k+1, so bit 0 is line 1 and bit 15 is line 16.
- R3: An output-word strobe to octal device 20 with function code 01 copies `wrData` into the extension mask. The new mask takes effect from the cycle after the strobe.
- R4: An output-word strobe to octal device 20 with function code 00 loads the standard-bank mask, which appears on `stdMask`. This write leaves the extension mask unchanged.
- R5: A control pulse to octal device 41 with function code 00 sets the task flag, and the task flag raises line 16.
- R6: The task flag clears when `intAck` is high while line 16 is the presented vector. An acknowledge of any other line leaves the task flag set.
- R7: An input strobe to octal device 41 with function code octal 10 drives the parameter `NODE_ID` onto `rdData` and raises `skip` in the same cycle. Any other input strobe leaves `skip` low and `rdData` zero.
- R8: When several pending lines are unmasked, the lowest-numbered line is selected.
- R9: After reset both masks are all ones and the task flag is clear. No line is pending even when every request input is high.
- R10: While `intEnable` is low, `irqPending` is low and `vector` is zero.
- R11: Strobes to other device addresses change no mask and do not post the task flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devAddr | input | 6 | I/O device address |
| funcCode | input | 4 | I/O function code |
| ctlPulse | input | 1 | Control-pulse strobe |
| outStrobe | input | 1 | Output-word strobe |
| inStrobe | input | 1 | Input-word strobe |
| wrData | input | 16 | Accumulator word for output commands |
| rdData | output | 16 | Word returned for input commands |
| skip | output | 1 | Skip response to an input command |
| reqIn | input | 15 | Level requests for lines 1 to 15 (bit 0 is line 1) |
| intEnable | input | 1 | Global interrupt enable |
| intAck | input | 1 | Processor acknowledge of the presented vector |
| irqPending | output | 1 | An unmasked line is selected |
| vector | output | 10 | Vector address of the selected line |
| stdMask | output | 16 | Standard-bank mask register |

## Verification
The bench builds the block with its default parameters: 16 lines, a 16-bit data word, a vector base of octal 064 and a node number of 23. These values put both ends of the vector window in reach: line 1 gives octal 064, and line 16, which is the task flag, gives octal 103. They also place the mask bit of the task line at the top of the word, so masking the internal flag is tested alongside masking the external lines. With the standard device codes, the bench can write to neighbouring addresses and confirm that those writes are ignored.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  typedef struct packed {
    logic loadExtMask;
    logic loadStdMask;
    logic postTask;
    logic readNode;
  } irqxStrobes_t;
endpackage

// File: rtl/irqx_ctrl.sv
module irqx_ctrl
  import irqx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int FC_W = 4,
  parameter logic [ADDR_W-1:0] DEV_MASK = 6'o20,
  parameter logic [ADDR_W-1:0] DEV_TASK = 6'o41,
  parameter logic [FC_W-1:0] FC_EXT = 4'o01,
  parameter logic [FC_W-1:0] FC_STD = 4'o00,
  parameter logic [FC_W-1:0] FC_POST = 4'o00,
  parameter logic [FC_W-1:0] FC_NODE = 4'o10
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [FC_W-1:0] funcCode,
  input  logic ctlPulse,
  input  logic outStrobe,
  input  logic inStrobe,
  output irqxStrobes_t strb
);
  logic hitMask, hitTask;

  always_comb begin
    hitMask = (devAddr == DEV_MASK);
    hitTask = (devAddr == DEV_TASK);
    strb.loadExtMask = outStrobe && hitMask && (funcCode == FC_EXT);
    strb.loadStdMask = outStrobe && hitMask && (funcCode == FC_STD);
    strb.postTask    = ctlPulse && hitTask && (funcCode == FC_POST);
    strb.readNode    = inStrobe && hitTask && (funcCode == FC_NODE);
  end

  // R11: a bus command decodes to at most one action
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadExtMask, strb.loadStdMask, strb.postTask, strb.readNode}));
endmodule

// File: rtl/irqx_datapath.sv
module irqx_datapath
  import irqx_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W = 16,
  parameter int VEC_W = 10,
  parameter logic [VEC_W-1:0] VEC_BASE = 10'o064,
  parameter logic [DATA_W-1:0] NODE_ID = 16'd23
) (
  input  logic clk,
  input  logic rstN,
  input  irqxStrobes_t strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_LINES-2:0] reqIn,
  input  logic intEnable,
  input  logic intAck,
  output logic [DATA_W-1:0] rdData,
  output logic skip,
  output logic irqPending,
  output logic [VEC_W-1:0] vector,
  output logic [DATA_W-1:0] stdMask
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [IDX_W-1:0] TASK_IDX = IDX_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] extMask;
  logic taskFlag;
  logic [NUM_LINES-1:0] lineReq, live;
  logic found;
  logic [IDX_W-1:0] winIdx;
  logic ackTask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extMask <= '1;
      stdMask <= '1;
    end else begin
      if (strb.loadExtMask) extMask <= wrData[NUM_LINES-1:0];
      if (strb.loadStdMask) stdMask <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) taskFlag <= 1'b0;
    else if (strb.postTask) taskFlag <= 1'b1;
    else if (ackTask) taskFlag <= 1'b0;
  end

  always_comb begin
    lineReq = {taskFlag, reqIn};
    live = lineReq & ~extMask;
    found = 1'b0;
    winIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (live[i]) begin
        found = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
    irqPending = found && intEnable;
    vector = irqPending ? (VEC_BASE + VEC_W'(winIdx)) : '0;
    ackTask = intAck && irqPending && (winIdx == TASK_IDX);
    skip = strb.readNode;
    rdData = strb.readNode ? NODE_ID : '0;
  end

  assert_vec_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> (vector >= VEC_BASE) && (vector <= VEC_BASE + VEC_W'(NUM_LINES - 1)));

  assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> (!irqPending && vector == '0));

  assert_task_post_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.postTask |=> taskFlag);

  assert_task_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ackTask && !strb.postTask) |=> !taskFlag);

  assert_skip_node_R7: assert property (@(posedge clk) disable iff (!rstN)
    skip |-> rdData == NODE_ID);
endmodule

// File: rtl/irqx_unit.sv
module irqx_unit
  import irqx_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int FC_W = 4,
  parameter int VEC_W = 10,
  parameter logic [VEC_W-1:0] VEC_BASE = 10'o064,
  parameter logic [DATA_W-1:0] NODE_ID = 16'd23
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [FC_W-1:0] funcCode,
  input  logic ctlPulse,
  input  logic outStrobe,
  input  logic inStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic skip,
  input  logic [NUM_LINES-2:0] reqIn,
  input  logic intEnable,
  input  logic intAck,
  output logic irqPending,
  output logic [VEC_W-1:0] vector,
  output logic [DATA_W-1:0] stdMask
);
  irqxStrobes_t strb;

  irqx_ctrl #(.ADDR_W(ADDR_W), .FC_W(FC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .funcCode(funcCode),
    .ctlPulse(ctlPulse), .outStrobe(outStrobe), .inStrobe(inStrobe),
    .strb(strb)
  );

  irqx_datapath #(
    .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .NODE_ID(NODE_ID)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .reqIn(reqIn),
    .intEnable(intEnable), .intAck(intAck), .rdData(rdData), .skip(skip),
    .irqPending(irqPending), .vector(vector), .stdMask(stdMask)
  );
endmodule

// File: tb/sim_irqx_unit.sv
`timescale 1ns/1ps
module sim_irqx_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] devAddr = '0;
  logic [3:0] funcCode = '0;
  logic ctlPulse = 1'b0, outStrobe = 1'b0, inStrobe = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic skip;
  logic [14:0] reqIn = '0;
  logic intEnable = 1'b0, intAck = 1'b0;
  logic irqPending;
  logic [9:0] vector;
  logic [15:0] stdMask;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqx_unit u0 (
    .clk(clk), .rstN(rstN), .devAddr(devAddr), .funcCode(funcCode),
    .ctlPulse(ctlPulse), .outStrobe(outStrobe), .inStrobe(inStrobe),
    .wrData(wrData), .rdData(rdData), .skip(skip), .reqIn(reqIn),
    .intEnable(intEnable), .intAck(intAck), .irqPending(irqPending),
    .vector(vector), .stdMask(stdMask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input int kind, input logic [5:0] dev, input logic [3:0] fc,
                     input logic [15:0] data);
    @(negedge clk);
    devAddr = dev; funcCode = fc; wrData = data;
    ctlPulse = (kind == 0); outStrobe = (kind == 1);
    @(negedge clk);
    ctlPulse = 0; outStrobe = 0; devAddr = '0; funcCode = '0; wrData = '0;
    #1;
  endtask

  task automatic ack();
    @(negedge clk); intAck = 1;
    @(negedge clk); intAck = 0;
    #1;
  endtask

  task automatic setReq(input logic [14:0] r);
    @(negedge clk); reqIn = r; #1;
  endtask

  task automatic t_reset();
    reqIn = '1; intEnable = 1; #1;
    check("R9 no pending after reset", irqPending, 0);
    check("R9 std mask all ones", stdMask, 16'hFFFF);
  endtask

  task automatic t_maskLoad();
    cmd(1, 6'o20, 4'o01, 16'h0000);
    setReq(15'h0001);
    check("R3 line1 pending after load", irqPending, 1);
    check("R1 line1 vector", vector, 10'o064);
    setReq(15'h4000);
    check("R1 line15 vector", vector, 10'o102);
    cmd(1, 6'o20, 4'o01, 16'h0001);
    setReq(15'h0009);
    check("R2 masked line1 skipped", vector, 10'o067);
  endtask

  task automatic t_priority();
    cmd(1, 6'o20, 4'o01, 16'h0000);
    setReq(15'h0114);
    check("R8 lowest line wins", vector, 10'o066);
  endtask

  task automatic t_stdMask();
    cmd(1, 6'o20, 4'o00, 16'h1234);
    check("R4 std mask loaded", stdMask, 16'h1234);
    setReq(15'h0001);
    check("R4 ext mask unchanged", vector, 10'o064);
  endtask

  task automatic t_enable();
    @(negedge clk); intEnable = 0; #1;
    check("R10 no pending when disabled", irqPending, 0);
    check("R10 vector zero when disabled", vector, 0);
    @(negedge clk); intEnable = 1; #1;
  endtask

  task automatic t_task();
    setReq('0);
    check("R5 idle before post", irqPending, 0);
    cmd(0, 6'o41, 4'o00, 16'h0);
    check("R5 task line vector", vector, 10'o103);
    setReq(15'h0002);
    check("R6 line2 ahead of task", vector, 10'o065);
    ack();
    setReq('0);
    check("R6 task kept after other ack", vector, 10'o103);
    cmd(1, 6'o20, 4'o01, 16'h8000);
    check("R2 task line masked", irqPending, 0);
    cmd(1, 6'o20, 4'o01, 16'h0000);
    check("R2 task line unmasked", vector, 10'o103);
    ack();
    check("R6 task cleared by ack", irqPending, 0);
  endtask

  task automatic t_node();
    @(negedge clk);
    inStrobe = 1; devAddr = 6'o41; funcCode = 4'o10; #1;
    check("R7 node number", rdData, 16'd23);
    check("R7 skip raised", skip, 1);
    funcCode = 4'o00; #1;
    check("R7 no skip other fc", skip, 0);
    check("R7 data zero other fc", rdData, 0);
    @(negedge clk); inStrobe = 0; devAddr = '0; funcCode = '0; #1;
  endtask

  task automatic t_other();
    cmd(0, 6'o42, 4'o00, 16'h0);
    check("R11 no task from other device", irqPending, 0);
    cmd(1, 6'o21, 4'o01, 16'hFFFF);
    setReq(15'h0001);
    check("R11 ext mask untouched", vector, 10'o064);
    check("R11 std mask untouched", stdMask, 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_maskLoad();
    t_priority();
    t_stdMask();
    t_enable();
    t_task();
    t_node();
    t_other();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule